// File: doc/BRIEF.md
# SCSI Asynchronous Handshake Transfer Engine

This block is the target-side byte mover for an 8-bit parallel SCSI bus that carries one parity bit. It uses the asynchronous REQ/ACK handshake in both directions.

A transfer begins with a one-cycle `start` pulse. The pulse carries a byte count and a direction select. In the write direction, bytes come in on a valid/ready stream. Each byte gets an odd parity bit and is placed on the bus, inverted, with REQ inactive. After a programmable setup time, the engine waits for ACK to be inactive, asserts REQ, and waits for ACK to go active. It then releases REQ and loads the next byte.

In the read direction, the engine waits for ACK to be inactive, asserts REQ, and waits for ACK to go active. It then releases REQ and captures all nine bus lines on that same edge. Each captured byte goes out on a result stream together with a parity-valid bit. A bad parity sets a sticky error flag.

The engine drives the external buffer direction and the nine data output enables only while a write is in progress. It raises `done` for one cycle after the last handshake.

Top module: `scsi_async_xfer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `req_n` is 1, `db_oe` is 0, `buf_dir_out` is 0, and `busy`, `done`, `par_err` and `rd_valid` are all 0.
- R2: Every bus line is active low, so a low pin is logic 1. Bits 7:0 carry the data byte and bit 8 carries the parity bit. `db_out_n` is the bitwise inverse of {parity, byte}, and a read byte is the inverse of `db_in_n[7:0]`.
- R3: Parity is odd. The driven parity bit makes the number of ones across the 9 logic-level bits odd. `rd_par_ok` is 1 exactly when the 9 captured logic-level bits hold an odd number of ones.
- R4: `db_oe` is all ones and `buf_dir_out` is 1 from the accepted first write byte until the last write handshake. At every other time, including the whole of a read transfer, both are 0.
- R5: With setup value S (0 is treated as 1) and ACK already inactive, REQ falls exactly S+1 clocks after the edge that changed `db_out_n`. It never falls sooner than S clocks after that edge.
- R6: `ack_n` passes through a two-flop synchronizer. REQ is asserted only after the synchronized ACK has been seen inactive, and REQ stays inactive for as long as ACK is held active.
- R7: During a read, REQ returns inactive on the edge that follows the synchronized ACK going active. The 9 bus lines are captured on that same edge, and `rd_valid` is high for exactly the first cycle in which `req_n` is high again.
- R8: `par_err` sets when a byte with bad parity is delivered. It stays set through the rest of the transfer and clears when the next transfer is accepted.
- R9: A write `start` whose count is odd or zero, or a read `start` whose count is zero, is ignored. `busy` stays 0, `wr_ready` stays 0, REQ stays inactive and no `done` is raised.
- R10: `busy` is 1 from the edge that accepts `start` until the end of the one-cycle `done` pulse. During the `done` cycle, REQ is inactive and the bus is released.
- R11: A write byte is taken on an edge where `wr_valid` and `wr_ready` are both high. While the source has no byte, REQ stays inactive and the previous byte stays driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request, sampled only when idle |
| xfer_write | input | 1 | 1 = write (target drives the bus), 0 = read |
| xfer_count | input | CNT_W | Number of bytes to move |
| setup_clks | input | DLY_W | Minimum data-to-REQ setup time in clocks (0 is treated as 1) |
| wr_data | input | 8 | Write byte from the source stream |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Engine takes a write byte this cycle |
| rd_data | output | 8 | Captured read byte |
| rd_par_ok | output | 1 | Parity of the captured byte is valid |
| rd_valid | output | 1 | One-cycle strobe for rd_data and rd_par_ok |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last handshake |
| par_err | output | 1 | Sticky read parity error |
| ack_n | input | 1 | ACK from the initiator, active low, asynchronous |
| db_in_n | input | 9 | Bus lines as sampled, active low |
| db_out_n | output | 9 | Bus values to drive, active low |
| db_oe | output | 9 | Per-line output enable |
| buf_dir_out | output | 1 | External buffer direction, 1 = toward the bus |
| req_n | output | 1 | REQ to the initiator, active low |

## Verification
A sequencer stuck in a wrong state shows up at the ports within the next handshake. Either REQ falls early relative to the last data change, falls while ACK is still active, or never falls at all, and the initiator model flags each of these in the same cycle. A wrong remaining-count shows up as a `done` pulse that comes one byte early or late, or a transfer that never ends. A bad capture edge or parity path is caught when the scoreboard compares the next `rd_valid` against its expected byte. A parity-error flag that fails to set or to clear is visible right after the affected transfer, and at the next accepted start.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

    localparam int BYTE_W = 8;
    localparam int BUS_W  = BYTE_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_LOAD,
        ST_W_SETUP,
        ST_W_ACKHI,
        ST_W_ACKLO,
        ST_R_ACKHI,
        ST_R_ACKLO,
        ST_FINISH
    } hs_state_e;

    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] data;
    } bus_word_t;

    // Odd parity: total ones over data and parity bit is odd.
    function automatic bus_word_t make_word(input logic [BYTE_W-1:0] d);
        bus_word_t w;
        w.data = d;
        w.par  = ~(^d);
        return w;
    endfunction

    function automatic logic word_ok(input bus_word_t w);
        return ^w;
    endfunction

    // Active-low bus: pin level is the inverse of the logic value.
    function automatic logic [BUS_W-1:0] to_pins(input bus_word_t w);
        return ~w;
    endfunction

    function automatic bus_word_t from_pins(input logic [BUS_W-1:0] p);
        return bus_word_t'(~p);
    endfunction

endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hs_setup_timer.sv
module hs_setup_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] setup_clks,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= setup_clks;
        end else if (cnt_q > DLY_W'(1)) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    // Last cycle of the setup window (a value of 0 behaves as 1).
    assign expired = (cnt_q <= DLY_W'(1));
endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
    import scsi_hs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              xfer_write,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              ack_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [BUS_W-1:0]  db_in_n,
    input  logic              timer_expired,
    output logic              timer_load,
    output logic              drive_en,
    output logic [BUS_W-1:0]  db_out_n,
    output logic              req_n,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_par_ok,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              par_err
);
    hs_state_e        state_q;
    logic [CNT_W-1:0] remain_q;
    bus_word_t        rx_word;
    logic             rx_ok;
    logic             last_byte;
    logic             wr_start_ok;
    logic             rd_start_ok;

    assign rx_word     = from_pins(db_in_n);
    assign rx_ok       = word_ok(rx_word);
    assign last_byte   = (remain_q == CNT_W'(1));
    assign wr_start_ok = xfer_write && (xfer_count != '0) && !xfer_count[0];
    assign rd_start_ok = !xfer_write && (xfer_count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            remain_q  <= '0;
            drive_en  <= 1'b0;
            db_out_n  <= '1;
            rd_data   <= '0;
            rd_par_ok <= 1'b0;
            rd_valid  <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start && wr_start_ok) begin
                        state_q  <= ST_W_LOAD;
                        remain_q <= xfer_count;
                        par_err  <= 1'b0;
                    end else if (start && rd_start_ok) begin
                        state_q  <= ST_R_ACKHI;
                        remain_q <= xfer_count;
                        par_err  <= 1'b0;
                    end
                end
                ST_W_LOAD: begin
                    if (wr_valid) begin
                        db_out_n <= to_pins(make_word(wr_data));
                        drive_en <= 1'b1;
                        state_q  <= ST_W_SETUP;
                    end
                end
                ST_W_SETUP: begin
                    if (timer_expired) state_q <= ST_W_ACKHI;
                end
                ST_W_ACKHI: begin
                    if (ack_hi) state_q <= ST_W_ACKLO;
                end
                ST_W_ACKLO: begin
                    if (!ack_hi) begin
                        remain_q <= remain_q - CNT_W'(1);
                        if (last_byte) begin
                            state_q  <= ST_FINISH;
                            drive_en <= 1'b0;
                            db_out_n <= '1;
                        end else begin
                            state_q <= ST_W_LOAD;
                        end
                    end
                end
                ST_R_ACKHI: begin
                    if (ack_hi) state_q <= ST_R_ACKLO;
                end
                ST_R_ACKLO: begin
                    if (!ack_hi) begin
                        rd_data   <= rx_word.data;
                        rd_par_ok <= rx_ok;
                        rd_valid  <= 1'b1;
                        if (!rx_ok) par_err <= 1'b1;
                        remain_q  <= remain_q - CNT_W'(1);
                        state_q   <= last_byte ? ST_FINISH : ST_R_ACKHI;
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_n      = !((state_q == ST_W_ACKLO) || (state_q == ST_R_ACKLO));
    assign wr_ready   = (state_q == ST_W_LOAD);
    assign timer_load = wr_ready && wr_valid;
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FINISH);

    // R8: the error flag only rises together with a bad-parity delivery
    a_r8_err_source: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> (rd_valid && !rd_par_ok));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/scsi_async_xfer.sv
module scsi_async_xfer
    import scsi_hs_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DLY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              xfer_write,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic [DLY_W-1:0]  setup_clks,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_par_ok,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              par_err,
    input  logic              ack_n,
    input  logic [8:0]        db_in_n,
    output logic [8:0]        db_out_n,
    output logic [8:0]        db_oe,
    output logic              buf_dir_out,
    output logic              req_n
);
    logic ack_hi;
    logic timer_load;
    logic timer_expired;
    logic drive_en;

    hs_ack_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ack_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ack_n),
        .sync_out (ack_hi)
    );

    hs_setup_timer #(.DLY_W(DLY_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load       (timer_load),
        .setup_clks (setup_clks),
        .expired    (timer_expired)
    );

    hs_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .xfer_write    (xfer_write),
        .xfer_count    (xfer_count),
        .ack_hi        (ack_hi),
        .wr_data       (wr_data),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .db_in_n       (db_in_n),
        .timer_expired (timer_expired),
        .timer_load    (timer_load),
        .drive_en      (drive_en),
        .db_out_n      (db_out_n),
        .req_n         (req_n),
        .rd_data       (rd_data),
        .rd_par_ok     (rd_par_ok),
        .rd_valid      (rd_valid),
        .busy          (busy),
        .done          (done),
        .par_err       (par_err)
    );

    assign db_oe       = {BUS_W{drive_en}};
    assign buf_dir_out = drive_en;

    // Setup-time monitor: clocks the driven bus value has been stable.
    logic [DLY_W:0]     since_q;
    logic [BUS_W-1:0]   prev_db_q;
    logic [DLY_W:0]     eff_setup;

    assign eff_setup = (setup_clks == '0) ? (DLY_W+1)'(1) : {1'b0, setup_clks};

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= '0;
            prev_db_q <= '1;
        end else begin
            prev_db_q <= db_out_n;
            if (db_out_n != prev_db_q) since_q <= (DLY_W+1)'(1);
            else if (since_q != '1)    since_q <= since_q + (DLY_W+1)'(1);
        end
    end

    // R5: REQ never asserts before the data has been stable for the setup time
    a_r5_setup_time: assert property (@(posedge clk) disable iff (rst)
        ($fell(req_n) && drive_en) |-> (since_q >= eff_setup));

    // R6: REQ asserts only after ACK was seen inactive
    a_r6_ack_order: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n) |-> $past(ack_hi));

    // R4: driving starts with REQ inactive
    a_r4_drive_req_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_dir_out) |-> req_n);

    // R7: in a read, REQ release coincides with a delivered byte
    a_r7_read_capture: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_n) && !$past(buf_dir_out)) |-> rd_valid);

    // R10: bus released and REQ idle during done
    a_r10_done_release: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_n && (db_oe == '0)));
endmodule

// File: tb/tb_scsi_async_xfer.sv
module tb_scsi_async_xfer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             xfer_write = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic [DLY_W-1:0] setup_clks = 4'd7;
    logic [7:0]       wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [7:0]       rd_data;
    logic             rd_par_ok;
    logic             rd_valid;
    logic             busy;
    logic             done;
    logic             par_err;
    logic             ack_n;
    logic [8:0]       db_in_n;
    logic [8:0]       db_out_n;
    logic [8:0]       db_oe;
    logic             buf_dir_out;
    logic             req_n;

    int checks = 0;
    int fails  = 0;
    bit ack_hold = 0;
    bit chk_setup = 1;

    logic [7:0] src_q[$];
    logic [8:0] exp_wq[$];
    logic [8:0] rd_src_q[$];
    logic [8:0] rd_exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_async_xfer #(.CNT_W(CNT_W), .DLY_W(DLY_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .start(start), .xfer_write(xfer_write),
        .xfer_count(xfer_count), .setup_clks(setup_clks),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_par_ok(rd_par_ok), .rd_valid(rd_valid),
        .busy(busy), .done(done), .par_err(par_err),
        .ack_n(ack_n), .db_in_n(db_in_n), .db_out_n(db_out_n),
        .db_oe(db_oe), .buf_dir_out(buf_dir_out), .req_n(req_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] good_w(input logic [7:0] d);
        return {~(^d), d};
    endfunction

    function automatic logic [8:0] bad_w(input logic [7:0] d);
        return {^d, d};
    endfunction

    // Write-byte source stream
    initial begin
        bit take = 0;
        forever begin
            @(negedge clk);
            if (take) begin
                void'(src_q.pop_front());
                take = 0;
            end
            if (src_q.size() > 0) begin
                wr_valid = 1'b1;
                wr_data  = src_q[0];
            end else begin
                wr_valid = 1'b0;
            end
            if (wr_valid && wr_ready) take = 1;
        end
    end

    // Initiator model: answers REQ, checks write bytes and setup timing
    initial begin
        logic [8:0] prev_db = '1;
        int cyc = 0;
        ack_n   = 1'b1;
        db_in_n = '1;
        forever begin
            @(negedge clk);
            if (db_out_n !== prev_db) begin
                prev_db = db_out_n;
                cyc = 0;
            end else begin
                cyc++;
            end
            if (ack_hold) begin
                ack_n = 1'b0;
                chk(req_n == 1'b1, "R6 req while ack held", req_n, 1);
            end else if (ack_n == 1'b0) begin
                ack_n = 1'b1;
            end else if (!req_n && buf_dir_out) begin
                logic [8:0] w;
                logic [8:0] e;
                int s;
                w = ~db_out_n;
                s = (setup_clks == 0) ? 1 : int'(setup_clks);
                if (exp_wq.size() == 0) begin
                    chk(0, "R2 unexpected write byte", w, 0);
                end else begin
                    e = exp_wq.pop_front();
                    chk(w[7:0] == e[7:0], "R2 write data", w[7:0], e[7:0]);
                    chk(w[8] == e[8], "R3 write parity bit", w[8], e[8]);
                    chk(($countones(w) % 2) == 1, "R3 odd ones", $countones(w), 1);
                end
                chk(db_oe == 9'h1FF && buf_dir_out, "R4 drive enables", db_oe, 9'h1FF);
                if (chk_setup) chk(cyc == s + 1, "R5 setup cycles", cyc, s + 1);
                @(negedge clk);
                ack_n = 1'b0;
                while (!req_n) @(negedge clk);
                ack_n = 1'b1;
            end else if (!req_n && !buf_dir_out) begin
                chk(db_oe == 9'h000, "R4 no drive on read", db_oe, 0);
                if (rd_src_q.size() > 0) db_in_n = ~rd_src_q.pop_front();
                @(negedge clk);
                ack_n = 1'b0;
                while (!req_n) @(negedge clk);
                ack_n = 1'b1;
                db_in_n = 9'h0AA;
            end
        end
    end

    // Read scoreboard monitor
    always @(negedge clk) begin
        if (rd_valid) begin
            chk(req_n == 1'b1, "R7 req released at capture", req_n, 1);
            if (rd_exp_q.size() == 0) begin
                chk(0, "R7 unexpected read byte", rd_data, 0);
            end else begin
                logic [8:0] e;
                e = rd_exp_q.pop_front();
                chk(rd_data == e[7:0], "R7 read data", rd_data, e[7:0]);
                chk(rd_par_ok == e[8], "R3 read parity flag", rd_par_ok, e[8]);
            end
        end
    end

    task automatic start_xfer(input bit wr, input int cnt, input bit expect_busy);
        @(negedge clk);
        xfer_write = wr;
        xfer_count = CNT_W'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (expect_busy) chk(busy == 1'b1, "R10 busy after start", busy, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R10 done raised", done, 1);
        chk(req_n && db_oe == 9'h000 && !buf_dir_out, "R10 bus released at done", db_oe, 0);
        @(negedge clk);
        chk(!done && !busy, "R10 done single pulse", {done, busy}, 0);
    endtask

    task automatic write_bytes(input logic [7:0] b[], input int s);
        setup_clks = DLY_W'(s);
        foreach (b[i]) begin
            src_q.push_back(b[i]);
            exp_wq.push_back(good_w(b[i]));
        end
        start_xfer(1, b.size(), 1);
        wait_done();
    endtask

    task automatic read_words(input logic [8:0] w[]);
        foreach (w[i]) begin
            rd_src_q.push_back(w[i]);
            rd_exp_q.push_back({(($countones(w[i]) % 2) == 1) ? 1'b1 : 1'b0, w[i][7:0]});
        end
        start_xfer(0, w.size(), 1);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_n && db_oe == 0 && !buf_dir_out && !busy && !done && !par_err && !rd_valid,
            "R1 reset outputs", {req_n, db_oe}, 10'h200);
        rst = 1'b0;
        @(negedge clk);
        chk(req_n && db_oe == 0 && !busy && !par_err, "R1 after reset", {req_n, db_oe}, 10'h200);

        write_bytes('{8'hA5, 8'h3C, 8'h00, 8'hFF}, 7);
        write_bytes('{8'h81, 8'h7E}, 3);
        write_bytes('{8'h01, 8'h02}, 1);

        // R6: ACK held active across the whole setup window
        chk_setup = 0;
        ack_hold  = 1;
        setup_clks = 4'd2;
        src_q.push_back(8'h55); src_q.push_back(8'hAA);
        exp_wq.push_back(good_w(8'h55)); exp_wq.push_back(good_w(8'hAA));
        start_xfer(1, 2, 1);
        repeat (20) @(negedge clk);
        ack_hold = 0;
        wait_done();
        chk_setup = 1;

        // R11: source stalls between bytes
        setup_clks = 4'd2;
        src_q.push_back(8'h12);
        exp_wq.push_back(good_w(8'h12)); exp_wq.push_back(good_w(8'h34));
        start_xfer(1, 2, 1);
        repeat (30) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk(req_n && wr_ready && db_oe == 9'h1FF && (~db_out_n) == good_w(8'h12),
                "R11 stalled source", {req_n, wr_ready, db_oe}, {2'b11, 9'h1FF});
            @(negedge clk);
        end
        src_q.push_back(8'h34);
        wait_done();

        // Reads
        read_words('{good_w(8'h5A), good_w(8'hC3), good_w(8'h00)});
        chk(par_err == 1'b0, "R8 no error on good reads", par_err, 0);
        read_words('{good_w(8'h11), bad_w(8'h22), good_w(8'h33)});
        chk(par_err == 1'b1, "R8 sticky error after bad byte", par_err, 1);
        rd_src_q.push_back(good_w(8'h44));
        rd_exp_q.push_back({1'b1, 8'h44});
        start_xfer(0, 1, 1);
        chk(par_err == 1'b0, "R8 cleared by new start", par_err, 0);
        wait_done();

        // R9: illegal counts ignored
        start_xfer(1, 3, 0);
        for (int i = 0; i < 12; i++) begin
            chk(!busy && !wr_ready && req_n && !done, "R9 odd write count ignored",
                {busy, wr_ready, req_n, done}, 4'b0010);
            @(negedge clk);
        end
        start_xfer(0, 0, 0);
        for (int i = 0; i < 12; i++) begin
            chk(!busy && req_n && !done, "R9 zero read count ignored", {busy, req_n, done}, 3'b010);
            @(negedge clk);
        end

        chk(exp_wq.size() == 0, "R2 all write bytes seen", exp_wq.size(), 0);
        chk(rd_exp_q.size() == 0, "R7 all read bytes seen", rd_exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule